// File: doc/BRIEF.md
# Capture and PWM Timer

A single 16-bit down-counter behind a small memory-mapped register port. Software picks one of two modes by writing field encodings. In edge-timing mode, a rising edge on the capture pin latches the running count and raises a sticky event flag, which can drive an interrupt. In PWM mode, the running count is compared with a match value to produce a periodic waveform, whose polarity can be inverted.

The counter starts from the interval value, counts down to zero, reloads, and never halts on a capture or at the end of a period. The interval can be rewritten while the counter runs, and the counter takes the new value at once. Reads return data one cycle after the read strobe.

Top module: `capture_pwm_timer`

## Requirements
- R1: After reset, every register reads zero, and `pwm_out`, `irq` and `bus_rdata` are 0.
- R2: The counter runs only when all three of these hold: the enable bit (CTRL bit 0) is 1, CFG equals 4, and MODE holds a valid mode. MODE is 0xA for PWM (field[1:0]=2, alt bit3=1, capture bit2=0) or 0x7 for edge timing (field=3, bit2=1, bit3=0). In every other case the counter holds the LOAD value.
- R3: While running, the counter steps down by one per cycle and reloads LOAD after reaching zero. Its period is LOAD+1 cycles, and it never stops on a capture or at the end of a period.
- R4: In PWM mode the registered output is high while the count exceeds MATCH. Each period therefore has LOAD−MATCH high cycles for MATCH ≤ LOAD.
- R5: CTRL bit 1 inverts the PWM output. When the timer is not running in PWM mode, `pwm_out` equals that bit.
- R6: A write to LOAD (offset 0x10) loads the counter on the same clock edge. A VALUE read issued in the following cycle returns the written value, and later periods use it.
- R7: In edge-timing mode, `cap_in` passes through a two-flop synchronizer. For a rising edge first sampled at clock edge A, the count present after edge A+1 is latched at edge A+2 and sets the status bit. VALUE (0x24) returns the latched count in edge-timing mode and the live count otherwise.
- R8: Falling edges, and rising edges while the timer is not running in edge-timing mode, leave the status bit (RIS, 0x1C bit 0) at 0.
- R9: The status bit stays set until a write with bit 0 = 1 to ICLR (0x20). A write with bit 0 = 0 has no effect.
- R10: `irq` is the registered AND of the status bit and MASK (0x18) bit 0.
- R11: `bus_rdata` updates on the edge of a read. Register widths are: CFG (0x00) 3 bits, MODE (0x04) 4 bits, CTRL (0x08) 2 bits, LOAD (0x10) 16 bits, MATCH (0x14) 16 bits. Unmapped addresses and ICLR read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| cap_in | input | 1 | Asynchronous capture pin |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the count stays within the interval, decrements and reloads as specified, and takes a newly written interval on the next edge. They also check that the status bit is sticky until cleared, that the interrupt tracks status AND mask, that the idle PWM level equals the polarity bit, and that status rises only in running edge-timing mode. Only the bench scenarios can show the duty cycle and polarity over a sweep of interval and match values, and the exact captured count for a given edge timing. They also cover the rejected mode encodings, readback widths, and the clear-by-one rule as seen at the ports.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  localparam int OFS_CFG   = 'h00;
  localparam int OFS_MODE  = 'h04;
  localparam int OFS_CTRL  = 'h08;
  localparam int OFS_LOAD  = 'h10;
  localparam int OFS_MATCH = 'h14;
  localparam int OFS_MASK  = 'h18;
  localparam int OFS_RIS   = 'h1C;
  localparam int OFS_ICLR  = 'h20;
  localparam int OFS_VALUE = 'h24;

  localparam logic [2:0] CFG_SPLIT = 3'd4;
  localparam logic [1:0] MF_PWM    = 2'd2;
  localparam logic [1:0] MF_EDGE   = 2'd3;

  typedef struct packed {
    logic       alt_sel;
    logic       cap_sel;
    logic [1:0] field;
  } mode_t;

  typedef struct packed {
    logic invert;
    logic enable;
  } ctrl_t;

  function automatic logic mode_is_pwm(input mode_t m);
    return (m.field == MF_PWM) && m.alt_sel && !m.cap_sel;
  endfunction

  function automatic logic mode_is_edge(input mode_t m);
    return (m.field == MF_EDGE) && m.cap_sel && !m.alt_sel;
  endfunction

endpackage

// File: rtl/cpt_edge_sync.sv
module cpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], din};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/cpt_counter.sv
module cpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_wdata,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load_wr)       cnt <= load_wdata;
    else if (!run)          cnt <= load_val;
    else if (cnt == '0)     cnt <= load_val;
    else                    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/cpt_pwm_gen.sv
module cpt_pwm_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             invert,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] match,
  output logic             pwm_out
);
  logic above;
  assign above = cnt > match;

  always_ff @(posedge clk) begin
    if (rst)         pwm_out <= 1'b0;
    else if (active) pwm_out <= above ^ invert;
    else             pwm_out <= invert;
  end
endmodule

// File: rtl/cpt_regs.sv
module cpt_regs
  import cpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cap_evt,
  input  logic              edge_mode,
  output logic [2:0]        cfg_q,
  output mode_t             mode_q,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  match_q,
  output logic              mask_q,
  output logic              ris_q,
  output logic              load_wr
);
  logic [ADDR_W-1:0] word_addr;
  logic              wr_en, rd_en;
  logic              sel_cfg, sel_mode, sel_ctrl, sel_load, sel_match;
  logic              sel_mask, sel_ris, sel_iclr, sel_value;
  logic [CNT_W-1:0]  cap_q;
  logic [DATA_W-1:0] rmux;
  logic [1:0]        unused_addr;
  logic [DATA_W-CNT_W-1:0] unused_wdata;

  assign unused_addr  = bus_addr[1:0];
  assign unused_wdata = bus_wdata[DATA_W-1:CNT_W];

  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_en     = bus_valid & bus_write;
  assign rd_en     = bus_valid & ~bus_write;

  assign sel_cfg   = word_addr == ADDR_W'(OFS_CFG);
  assign sel_mode  = word_addr == ADDR_W'(OFS_MODE);
  assign sel_ctrl  = word_addr == ADDR_W'(OFS_CTRL);
  assign sel_load  = word_addr == ADDR_W'(OFS_LOAD);
  assign sel_match = word_addr == ADDR_W'(OFS_MATCH);
  assign sel_mask  = word_addr == ADDR_W'(OFS_MASK);
  assign sel_ris   = word_addr == ADDR_W'(OFS_RIS);
  assign sel_iclr  = word_addr == ADDR_W'(OFS_ICLR);
  assign sel_value = word_addr == ADDR_W'(OFS_VALUE);

  assign load_wr = wr_en & sel_load;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      mode_q  <= '0;
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      mask_q  <= 1'b0;
    end else if (wr_en) begin
      if (sel_cfg)   cfg_q   <= bus_wdata[2:0];
      if (sel_mode)  mode_q  <= mode_t'(bus_wdata[3:0]);
      if (sel_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[1:0]);
      if (sel_load)  load_q  <= bus_wdata[CNT_W-1:0];
      if (sel_match) match_q <= bus_wdata[CNT_W-1:0];
      if (sel_mask)  mask_q  <= bus_wdata[0];
    end
  end

  // event status: a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                                ris_q <= 1'b0;
    else if (cap_evt)                       ris_q <= 1'b1;
    else if (wr_en && sel_iclr && bus_wdata[0]) ris_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_evt) cap_q <= cnt;
  end

  always_comb begin
    rmux = '0;
    if (sel_cfg)        rmux = DATA_W'(cfg_q);
    else if (sel_mode)  rmux = DATA_W'(mode_q);
    else if (sel_ctrl)  rmux = DATA_W'(ctrl_q);
    else if (sel_load)  rmux = DATA_W'(load_q);
    else if (sel_match) rmux = DATA_W'(match_q);
    else if (sel_mask)  rmux = DATA_W'(mask_q);
    else if (sel_ris)   rmux = DATA_W'(ris_q);
    else if (sel_value) rmux = edge_mode ? DATA_W'(cap_q) : DATA_W'(cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rmux;
  end
endmodule

// File: rtl/capture_pwm_timer.sv
module capture_pwm_timer
  import cpt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  logic [2:0]       cfg_q;
  mode_t            mode_q;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q, match_q, cnt;
  logic             mask_q, ris_q, load_wr;
  logic             pwm_mode, cap_mode, run, pwm_run, cap_run, inv;
  logic             cap_rise, cap_evt;

  assign pwm_mode = (cfg_q == CFG_SPLIT) && mode_is_pwm(mode_q);
  assign cap_mode = (cfg_q == CFG_SPLIT) && mode_is_edge(mode_q);
  assign run      = ctrl_q.enable && (pwm_mode || cap_mode);
  assign pwm_run  = run && pwm_mode;
  assign cap_run  = run && cap_mode;
  assign inv      = ctrl_q.invert;
  assign cap_evt  = cap_rise && cap_run;

  cpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .cap_evt(cap_evt), .edge_mode(cap_mode),
    .cfg_q(cfg_q), .mode_q(mode_q), .ctrl_q(ctrl_q), .load_q(load_q),
    .match_q(match_q), .mask_q(mask_q), .ris_q(ris_q), .load_wr(load_wr)
  );

  cpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .load_wr(load_wr),
    .load_wdata(bus_wdata[CNT_W-1:0]), .load_val(load_q), .cnt(cnt)
  );

  cpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cap_in), .rise(cap_rise)
  );

  cpt_pwm_gen #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst(rst), .active(pwm_run), .invert(inv),
    .cnt(cnt), .match(match_q), .pwm_out(pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ris_q & mask_q;
  end
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker
  import cpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              clr_bit,
  input logic [CNT_W-1:0]  ld_data,
  input logic              run,
  input logic              pwm_run,
  input logic              cap_run,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load_q,
  input logic              load_wr,
  input logic              ris_q,
  input logic              mask_q,
  input logic              inv,
  input logic              pwm_out,
  input logic              irq
);
  logic clr_hit;
  assign clr_hit = bus_valid && bus_write && clr_bit &&
                   ({bus_addr[ADDR_W-1:2], 2'b00} == ADDR_W'(OFS_ICLR));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= load_q);

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !load_wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !load_wr && cnt == '0) |=> (cnt == $past(load_q)));

  assert_load_next_R6: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> (cnt == $past(ld_data)));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !pwm_run |=> (pwm_out == $past(inv)));

  assert_event_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ris_q) |-> $past(cap_run));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ris_q && !clr_hit) |=> ris_q);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(ris_q && mask_q)));
endmodule

bind capture_pwm_timer cpt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .clr_bit(bus_wdata[0]), .ld_data(bus_wdata[CNT_W-1:0]),
  .run(run), .pwm_run(pwm_run), .cap_run(cap_run), .cnt(cnt),
  .load_q(load_q), .load_wr(load_wr), .ris_q(ris_q), .mask_q(mask_q),
  .inv(inv), .pwm_out(pwm_out), .irq(irq)
);

// File: tb/capture_pwm_timer_tb.sv
module capture_pwm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CFG = 8'h00, A_MODE = 8'h04, A_CTRL = 8'h08,
                         A_LOAD = 8'h10, A_MATCH = 8'h14, A_MASK = 8'h18,
                         A_RIS = 8'h1C, A_ICLR = 8'h20, A_VALUE = 8'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  capture_pwm_timer u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pwm_setup(input int l, input int m, input bit iv);
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CFG, 32'h4);
    bus_wr(A_MODE, 32'hA);
    bus_wr(A_LOAD, l);
    bus_wr(A_MATCH, m);
    bus_wr(A_CTRL, iv ? 32'h3 : 32'h1);
  endtask

  task automatic measure(input int win, output int highs);
    highs = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int highs, e0, exp1, exp2;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    bus_rd(A_CFG, d);   check(d == 0, "R1 cfg", d, 0);
    bus_rd(A_CTRL, d);  check(d == 0, "R1 ctrl", d, 0);
    bus_rd(A_LOAD, d);  check(d == 0, "R1 load", d, 0);

    // R11: readback widths and unmapped space
    bus_wr(A_LOAD, 32'hFFFF_1234);  bus_rd(A_LOAD, d);  check(d == 32'h1234, "R11 load", d, 32'h1234);
    bus_wr(A_MATCH, 32'hABCD_0042); bus_rd(A_MATCH, d); check(d == 32'h42, "R11 match", d, 32'h42);
    bus_wr(A_CFG, 32'hFF);  bus_rd(A_CFG, d);  check(d == 32'h7, "R11 cfg", d, 7);
    bus_wr(A_MODE, 32'hFF); bus_rd(A_MODE, d); check(d == 32'hF, "R11 mode", d, 15);
    bus_rd(8'h3C, d);   check(d == 0, "R11 unmapped", d, 0);
    bus_rd(A_ICLR, d);  check(d == 0, "R11 iclr", d, 0);
    bus_wr(A_CFG, 0); bus_wr(A_MODE, 0);

    // R4, R5: duty and polarity sweep over small interval and match values
    for (int l = 0; l <= 6; l++)
      for (int m = 0; m <= l; m++)
        for (int iv = 0; iv < 2; iv++) begin
          pwm_setup(l, m, iv[0]);
          idle(l + 4);
          measure(3 * (l + 1), highs);
          if (iv == 0) check(highs == 3 * (l - m), "R4 duty", highs, 3 * (l - m));
          else         check(highs == 3 * (m + 1), "R5 inverted duty", highs, 3 * (m + 1));
        end

    // R5: idle level follows polarity when disabled
    bus_wr(A_CTRL, 32'h2); idle(3);
    check(pwm_out == 1'b1, "R5 idle inverted", pwm_out, 1);
    bus_wr(A_CTRL, 32'h0); idle(3);
    check(pwm_out == 1'b0, "R5 idle plain", pwm_out, 0);

    // R2: wrong CFG or wrong mode keeps the counter at LOAD
    bus_wr(A_CFG, 0); bus_wr(A_MODE, 32'hA); bus_wr(A_LOAD, 9); bus_wr(A_CTRL, 32'h3);
    idle(5);  bus_rd(A_VALUE, d); check(d == 9, "R2 cfg gate", d, 9);
    check(pwm_out == 1'b1, "R2 output idle", pwm_out, 1);
    idle(7);  bus_rd(A_VALUE, d); check(d == 9, "R2 cfg gate later", d, 9);
    bus_wr(A_CFG, 4); bus_wr(A_MODE, 32'h2);
    idle(6);  bus_rd(A_VALUE, d); check(d == 9, "R2 mode gate", d, 9);
    bus_wr(A_MODE, 32'hE);
    idle(6);  bus_rd(A_VALUE, d); check(d == 9, "R2 mode gate cap bit", d, 9);
    bus_wr(A_CTRL, 0);

    // R6: interval rewrite while running
    pwm_setup(50, 10, 1'b0);
    idle(30);
    bus_wr(A_LOAD, 20);
    bus_rd(A_VALUE, d); check(d == 20, "R6 next cycle", d, 20);
    idle(30);
    measure(63, highs); check(highs == 30, "R6 new period", highs, 30);

    // R7, R8, R9, R10: edge timing
    bus_wr(A_CTRL, 0); bus_wr(A_CFG, 4); bus_wr(A_MODE, 32'h7);
    bus_wr(A_LOAD, 1000); bus_wr(A_MASK, 0);
    cap_in = 1'b1; idle(5);
    bus_rd(A_RIS, d); check(d == 0, "R8 edge while disabled", d, 0);
    bus_wr(A_CTRL, 1); e0 = cyc;
    idle(4); cap_in = 1'b0; idle(5);
    bus_rd(A_RIS, d); check(d == 0, "R8 falling edge", d, 0);
    idle(3);
    cap_in = 1'b1; exp1 = 1000 - (cyc + 2 - e0);
    idle(5);
    bus_rd(A_RIS, d);   check(d == 1, "R7 status set", d, 1);
    bus_rd(A_VALUE, d); check(d == exp1, "R7 captured count", d, exp1);
    check(irq == 1'b0, "R10 masked", irq, 0);
    bus_wr(A_MASK, 1); idle(2);
    check(irq == 1'b1, "R10 unmasked", irq, 1);
    bus_wr(A_ICLR, 0); idle(1);
    bus_rd(A_RIS, d); check(d == 1, "R9 write zero ignored", d, 1);
    check(irq == 1'b1, "R10 irq held", irq, 1);
    cap_in = 1'b0; idle(4);
    cap_in = 1'b1; exp2 = 1000 - (cyc + 2 - e0);
    idle(5);
    bus_rd(A_VALUE, d); check(d == exp2, "R3 R7 count kept running", d, exp2);
    bus_wr(A_ICLR, 1); idle(2);
    bus_rd(A_RIS, d); check(d == 0, "R9 cleared", d, 0);
    check(irq == 1'b0, "R10 irq dropped", irq, 0);

    // R8: rising edge in PWM mode is ignored
    bus_wr(A_CTRL, 0); bus_wr(A_MODE, 32'hA); bus_wr(A_CTRL, 1);
    cap_in = 1'b0; idle(4); cap_in = 1'b1; idle(5);
    bus_rd(A_RIS, d); check(d == 0, "R8 edge in pwm mode", d, 0);
    check(irq == 1'b0, "R8 no irq", irq, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule